// File: doc/BRIEF.md
# Delayed Branch Sequencer

This block steers the fetch address of a processor whose branches have one delay slot. When the decode stage reports that a delayed branch issues, the sequencer samples everything the branch depends on in that same cycle: the general register for an indirect jump or call, the return pointer for a return, and the condition flags together with the relative target for a conditional branch. It then lets exactly one instruction execute in the slot, and in the cycle after that instruction retires it presents one redirect address to fetch. That address is the frozen target if the branch is taken, and the address just past the slot if it is not.

For a delayed call the sequencer produces the return-pointer write in the issue cycle. The saved address points past the slot instruction, so the return resumes after the slot. From the issue cycle through the retirement of the slot instruction, it masks acceptance of traps, interrupts and non-maskable interrupts. A request raised in that window waits and is accepted once the pair completes. If a multi-cycle instruction or another branch shows up in the slot, the sequencer raises a one-cycle illegal-slot pulse and finishes the branch anyway.

Top module: `delay_branch_seq`

## Requirements
- R1: After reset the sequencer is idle. `irqInhibit`, `redirectValid`, `illegalSlot` and `rpWrite` are low, and a raised `irqReq` is accepted at once on `eitAccept`.
- R2: For a jump (`issueKind`=0) the redirect address is the `regVal` value of the issue cycle. A `regVal` change in the slot cycle has no effect on it.
- R3: For a call (`issueKind`=1), `rpWrite` is high in the issue cycle with `rpWdata` = `issuePc` + 2*`INSN_BYTES`, and the redirect goes to the issue-cycle `regVal`.
- R4: For a return (`issueKind`=2) the redirect address is the `rpVal` value of the issue cycle. A return-pointer change in the slot cycle has no effect on it.
- R5: A conditional branch (`issueKind`=3) is taken when ((`ccFlags` & `condMask`) != 0) XOR `condInvert`, using the issue-cycle values. When taken it goes to the issue-cycle `condTarget`. A flag change in the slot cycle has no effect.
- R6: A conditional branch that is not taken redirects to `issuePc` + 2*`INSN_BYTES`.
- R7: `irqInhibit` is high from the issue cycle through the slot-retire cycle and low in the cycle after. `eitAccept` equals `irqReq` AND NOT `irqInhibit`, so a request held during the pair is accepted in the redirect cycle.
- R8: A slot instruction with `slotMulti` high raises `illegalSlot` for exactly its retire cycle, and the redirect still follows in the next cycle.
- R9: A branch issue while a slot is pending counts as the slot instruction. It raises `illegalSlot`, latches nothing new, and the first branch's redirect follows.
- R10: The sequencer waits any number of cycles for the slot instruction. `redirectValid` is high for exactly one cycle, the cycle after the slot retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A delayed branch issues from decode this cycle |
| issueKind | input | 2 | 0 jump, 1 call, 2 return, 3 conditional |
| issuePc | input | ADDR_W | Address of the branch instruction |
| regVal | input | ADDR_W | Current value of the indirect target register |
| rpVal | input | ADDR_W | Current return pointer value |
| ccFlags | input | FLAG_W | Current condition flags |
| condMask | input | FLAG_W | Flags tested by a conditional branch |
| condInvert | input | 1 | Inverts the conditional test |
| condTarget | input | ADDR_W | Target of a conditional branch |
| slotValid | input | 1 | The slot instruction retires this cycle |
| slotMulti | input | 1 | The slot instruction is multi-cycle |
| irqReq | input | 1 | Trap or interrupt request pending |
| irqInhibit | output | 1 | Exception acceptance blocked |
| eitAccept | output | 1 | Pending request accepted this cycle |
| redirectValid | output | 1 | Fetch redirect this cycle |
| redirectAddr | output | ADDR_W | Next fetch address |
| rpWrite | output | 1 | Call writes the return pointer |
| rpWdata | output | ADDR_W | Return address past the slot |
| illegalSlot | output | 1 | Disallowed instruction in the slot |

## Verification
Two pairs can coincide. The first is the slot instruction retiring while a sampled operand changes. Each slot cycle drives a new `regVal`, `rpVal` or `ccFlags` together with `slotValid`, and the redirect address must match the issue-cycle operand. The second is a pending interrupt request meeting the branch window. `irqReq` stays high from before issue, through several idle slot cycles, into the redirect cycle, and `eitAccept` is judged low throughout the window and high exactly when the redirect appears.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [1:0] {
    BR_JUMP = 2'd0,
    BR_CALL = 2'd1,
    BR_RET  = 2'd2,
    BR_COND = 2'd3
  } brKind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SLOT  = 2'd1,
    SQ_REDIR = 2'd2
  } seqState_e;

  typedef struct packed {
    logic capture;
    logic redirect;
  } dbsStrobe_t;

endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic       slotValid,
  input  logic       slotMulti,
  output dbsStrobe_t strb,
  output logic       irqInhibit,
  output logic       illegalSlot,
  output logic       redirectValid
);

  seqState_e stateQ, stateD;
  logic issueAccept, slotDone, inSlot;

  assign inSlot      = (stateQ == SQ_SLOT);
  assign issueAccept = issueValid && !inSlot;
  assign slotDone    = inSlot && (slotValid || issueValid);
  assign illegalSlot = inSlot && (issueValid || (slotValid && slotMulti));

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      SQ_SLOT:  if (slotDone) stateD = SQ_REDIR;
      default:  stateD = issueAccept ? SQ_SLOT : SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= SQ_IDLE;
    else       stateQ <= stateD;
  end

  assign strb.capture   = issueAccept;
  assign strb.redirect  = (stateQ == SQ_REDIR);
  assign redirectValid  = strb.redirect;
  assign irqInhibit     = inSlot || issueValid;

  p_issue_pends_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueAccept |=> (stateQ == SQ_SLOT));

  p_retire_redirects_r10: assert property (@(posedge clk) disable iff (!rstN)
    slotDone |=> redirectValid);

  p_illegal_then_redirect_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegalSlot |=> redirectValid);

  p_redirect_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !redirectValid);

  p_inhibit_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && !issueValid) |-> !irqInhibit);

endmodule

// File: rtl/dbs_datapath.sv
module dbs_datapath
  import dbs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FLAG_W     = 4,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbsStrobe_t        strb,
  input  logic [1:0]        issueKind,
  input  logic [ADDR_W-1:0] issuePc,
  input  logic [ADDR_W-1:0] regVal,
  input  logic [ADDR_W-1:0] rpVal,
  input  logic [FLAG_W-1:0] ccFlags,
  input  logic [FLAG_W-1:0] condMask,
  input  logic              condInvert,
  input  logic [ADDR_W-1:0] condTarget,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic              rpWrite,
  output logic [ADDR_W-1:0] rpWdata
);

  localparam logic [ADDR_W-1:0] PAST_SLOT = ADDR_W'(2 * INSN_BYTES);

  brKind_e           kind;
  logic [ADDR_W-1:0] tgtD, tgtQ, seqAddr, seqQ;
  logic              takenD, takenQ;

  assign kind    = brKind_e'(issueKind);
  assign seqAddr = issuePc + PAST_SLOT;

  always_comb begin
    tgtD   = regVal;
    takenD = 1'b1;
    case (kind)
      BR_RET:  tgtD = rpVal;
      BR_COND: begin
        tgtD   = condTarget;
        takenD = (|(ccFlags & condMask)) ^ condInvert;
      end
      default: tgtD = regVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtQ   <= '0;
      seqQ   <= '0;
      takenQ <= 1'b0;
    end else if (strb.capture) begin
      tgtQ   <= tgtD;
      seqQ   <= seqAddr;
      takenQ <= takenD;
    end
  end

  assign redirectAddr = takenQ ? tgtQ : seqQ;
  assign rpWrite      = strb.capture && (kind == BR_CALL);
  assign rpWdata      = seqAddr;

  p_ret_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && kind == BR_RET) |=> (tgtQ == $past(rpVal)));

  p_uncond_taken_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && kind != BR_COND) |=> takenQ);

  p_hold_without_issue_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(tgtQ));

endmodule

// File: rtl/delay_branch_seq.sv
module delay_branch_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FLAG_W     = 4,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueKind,
  input  logic [ADDR_W-1:0] issuePc,
  input  logic [ADDR_W-1:0] regVal,
  input  logic [ADDR_W-1:0] rpVal,
  input  logic [FLAG_W-1:0] ccFlags,
  input  logic [FLAG_W-1:0] condMask,
  input  logic              condInvert,
  input  logic [ADDR_W-1:0] condTarget,
  input  logic              slotValid,
  input  logic              slotMulti,
  input  logic              irqReq,
  output logic              irqInhibit,
  output logic              eitAccept,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic              rpWrite,
  output logic [ADDR_W-1:0] rpWdata,
  output logic              illegalSlot
);

  dbsStrobe_t strb;

  dbs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .slotValid(slotValid),
    .slotMulti(slotMulti), .strb(strb), .irqInhibit(irqInhibit),
    .illegalSlot(illegalSlot), .redirectValid(redirectValid)
  );

  dbs_datapath #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .INSN_BYTES(INSN_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .issueKind(issueKind), .issuePc(issuePc),
    .regVal(regVal), .rpVal(rpVal), .ccFlags(ccFlags), .condMask(condMask),
    .condInvert(condInvert), .condTarget(condTarget), .redirectAddr(redirectAddr),
    .rpWrite(rpWrite), .rpWdata(rpWdata)
  );

  assign eitAccept = irqReq && !irqInhibit;

  p_no_accept_in_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid || illegalSlot) |-> !eitAccept);

endmodule

// File: tb/delay_branch_seq_tb.sv
module delay_branch_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic [1:0]    issueKind = '0;
  logic [AW-1:0] issuePc = '0, regVal = '0, rpVal = '0, condTarget = '0;
  logic [FW-1:0] ccFlags = '0, condMask = '0;
  logic          condInvert = 1'b0, slotValid = 1'b0, slotMulti = 1'b0, irqReq = 1'b0;
  logic          irqInhibit, eitAccept, redirectValid, rpWrite, illegalSlot;
  logic [AW-1:0] redirectAddr, rpWdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  delay_branch_seq dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueKind(issueKind),
    .issuePc(issuePc), .regVal(regVal), .rpVal(rpVal), .ccFlags(ccFlags),
    .condMask(condMask), .condInvert(condInvert), .condTarget(condTarget),
    .slotValid(slotValid), .slotMulti(slotMulti), .irqReq(irqReq),
    .irqInhibit(irqInhibit), .eitAccept(eitAccept), .redirectValid(redirectValid),
    .redirectAddr(redirectAddr), .rpWrite(rpWrite), .rpWdata(rpWdata),
    .illegalSlot(illegalSlot)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue a branch, run one slot instruction that scrambles operands, check redirect.
  task automatic runBranch(input string req, input logic [1:0] kind, input logic [AW-1:0] pc,
                           input logic [AW-1:0] rv, input logic [AW-1:0] rp,
                           input logic [FW-1:0] fl, input logic [FW-1:0] mk, input logic inv,
                           input logic [AW-1:0] ct, input logic multi, input logic [AW-1:0] expAddr);
    @(negedge clk);
    issueValid = 1; issueKind = kind; issuePc = pc; regVal = rv; rpVal = rp;
    ccFlags = fl; condMask = mk; condInvert = inv; condTarget = ct;
    #1;
    chk({req, " inhibit at issue"}, AW'(irqInhibit), 1);
    chk({req, " rpWrite at issue"}, AW'(rpWrite), AW'(kind == 2'd1));
    if (kind == 2'd1) chk({req, " R3 rpWdata"}, rpWdata, pc + 4);
    @(negedge clk);
    issueValid = 0; slotValid = 1; slotMulti = multi;
    regVal = ~rv; rpVal = ~rp; ccFlags = ~fl; condTarget = ~ct;
    #1;
    chk({req, " R7 inhibit in slot"}, AW'(irqInhibit), 1);
    chk({req, " R8 illegal in slot"}, AW'(illegalSlot), AW'(multi));
    chk({req, " R10 no early redirect"}, AW'(redirectValid), 0);
    @(negedge clk);
    slotValid = 0; slotMulti = 0;
    #1;
    chk({req, " R10 redirect valid"}, AW'(redirectValid), 1);
    chk({req, " redirect addr"}, redirectAddr, expAddr);
    chk({req, " R7 inhibit dropped"}, AW'(irqInhibit), 0);
    chk({req, " R8 illegal single pulse"}, AW'(illegalSlot), 0);
    @(negedge clk);
    #1;
    chk({req, " R10 redirect one cycle"}, AW'(redirectValid), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    irqReq = 1; #1;
    chk("R1 inhibit", AW'(irqInhibit), 0);
    chk("R1 redirect", AW'(redirectValid), 0);
    chk("R1 illegal", AW'(illegalSlot), 0);
    chk("R1 rpWrite", AW'(rpWrite), 0);
    chk("R1 accept", AW'(eitAccept), 1);
    irqReq = 0;
  endtask

  // R7/R10: slot arrives late while an interrupt request is held.
  task automatic testIrqWait();
    @(negedge clk);
    irqReq = 1; #1;
    chk("R7 accept before", AW'(eitAccept), 1);
    @(negedge clk);
    issueValid = 1; issueKind = 2'd0; issuePc = 32'h0000_5000; regVal = 32'h0000_6000;
    #1;
    chk("R7 blocked at issue", AW'(eitAccept), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      issueValid = 0; regVal = 32'h0000_0BAD;
      #1;
      chk("R7 blocked while waiting", AW'(eitAccept), 0);
      chk("R10 waiting no redirect", AW'(redirectValid), 0);
    end
    @(negedge clk);
    slotValid = 1; #1;
    chk("R7 blocked at retire", AW'(eitAccept), 0);
    @(negedge clk);
    slotValid = 0; #1;
    chk("R7 accepted at redirect", AW'(eitAccept), 1);
    chk("R10 redirect after wait", AW'(redirectValid), 1);
    chk("R2 addr after wait", redirectAddr, 32'h0000_6000);
    irqReq = 0;
    @(negedge clk);
  endtask

  // R9: a second branch lands in the slot.
  task automatic testBranchInSlot();
    @(negedge clk);
    issueValid = 1; issueKind = 2'd2; issuePc = 32'h0000_7000; rpVal = 32'h0000_7700;
    @(negedge clk);
    issueKind = 2'd0; regVal = 32'h0000_9900; rpVal = 32'h0000_1234;
    #1;
    chk("R9 illegal on branch in slot", AW'(illegalSlot), 1);
    chk("R9 no rpWrite", AW'(rpWrite), 0);
    @(negedge clk);
    issueValid = 0; #1;
    chk("R9 redirect follows", AW'(redirectValid), 1);
    chk("R9 first target kept", redirectAddr, 32'h0000_7700);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    runBranch("R2 jump", 2'd0, 32'h0000_1000, 32'h0000_2000, 32'h0, 4'h0, 4'h0, 1'b0, 32'h0, 1'b0, 32'h0000_2000);
    runBranch("R3 call", 2'd1, 32'h0000_1100, 32'h0000_3000, 32'h0, 4'h0, 4'h0, 1'b0, 32'h0, 1'b0, 32'h0000_3000);
    runBranch("R4 return", 2'd2, 32'h0000_1200, 32'h0, 32'h0000_4440, 4'h0, 4'h0, 1'b0, 32'h0, 1'b0, 32'h0000_4440);
    runBranch("R5 cond taken", 2'd3, 32'h0000_1300, 32'h0, 32'h0, 4'h2, 4'h2, 1'b0, 32'h0000_8000, 1'b0, 32'h0000_8000);
    runBranch("R6 cond not taken", 2'd3, 32'h0000_1400, 32'h0, 32'h0, 4'h0, 4'h2, 1'b0, 32'h0000_8100, 1'b0, 32'h0000_1404);
    runBranch("R5 cond inverted", 2'd3, 32'h0000_1500, 32'h0, 32'h0, 4'h0, 4'h2, 1'b1, 32'h0000_8200, 1'b0, 32'h0000_8200);
    runBranch("R8 multi slot", 2'd0, 32'h0000_1600, 32'h0000_A000, 32'h0, 4'h0, 4'h0, 1'b0, 32'h0, 1'b1, 32'h0000_A000);
    testIrqWait();
    testBranchInSlot();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule